// File: doc/BRIEF.md
# Dual-Loop Power-Down and Counter-Reset Sequencer

This block sits between the programming latches of a two-loop frequency synthesizer and the analog sections of its two loops, IF (loop index 0) and RF (loop index 1). For each loop it receives three control bits: power-down request, charge-pump three-state request and counter-reset request. It also receives one load-enable commit strobe. The block copies all bits into its own latch only on a commit. From the latched bits it drives, per loop, the charge-pump three-state control, the divider hold (load-state) control and the section power-down. A shared output enables the reference oscillator.

The three-state bit in the committed word sets how the loop powers down. If the pump was left active, the loop goes down in two steps: the pump is three-stated first, and after a programmable number of clock cycles the section powers down. If the word also three-states the pump, the section powers down straight away, on the commit. Committing a 0 power-down bit returns the loop to normal on the next clock, from any state. A counter-reset request holds both dividers of its loop and three-states its pump. Both dividers are released together by one hold signal, so they restart aligned.

Top module: `dual_pd_ctrl`

## Requirements
- R1: After reset every output is low except ref_en_o, which is high, and both loop status fields read 00 (running).
- R2: Control inputs are copied only in a cycle where commit_i is high; changes to pd_i, tri_i or crst_i without commit_i leave every output unchanged.
- R3: A commit with pd_i=1 and tri_i=0 to a running loop sets its status to 01 (three-stating) with cp_tristate_o high and sect_pd_o low for exactly PD_WAIT cycles (default 2), after which status becomes 10 (powered down).
- R4: A commit with pd_i=1 and tri_i=1 sets status 10 and sect_pd_o high on the clock edge that takes the commit, with no three-stating phase.
- R5: While a loop is powered down, its sect_pd_o, div_hold_o and cp_tristate_o are all high.
- R6: ref_en_o is low if and only if the latched power-down bits of both loops are 1; it updates one cycle after the commit.
- R7: A commit with pd_i=0 returns that loop to status 00 on the next cycle, from the three-stating or powered-down state; sect_pd_o falls at the same time.
- R8: A latched counter-reset bit holds div_hold_o and cp_tristate_o high for its loop. Clearing it by a commit releases the hold on the next cycle; one hold signal drives both dividers.
- R9: A latched three-state bit with no power-down keeps cp_tristate_o high while div_hold_o and sect_pd_o stay low and status stays 00.
- R10: Each loop uses bit l of every per-loop input and output vector (0 = IF, 1 = RF) and status_o[2l+1:2l]. Requests on one loop do not change the other loop's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| commit_i | input | 1 | Load-enable commit strobe, one cycle |
| pd_i | input | 2 | Power-down request per loop |
| tri_i | input | 2 | Charge-pump three-state request per loop |
| crst_i | input | 2 | Counter-reset request per loop |
| cp_tristate_o | output | 2 | Charge pump three-stated, per loop |
| div_hold_o | output | 2 | R and N dividers held in load state, per loop |
| sect_pd_o | output | 2 | Section powered down and input debiased, per loop |
| ref_en_o | output | 1 | Reference oscillator enable |
| status_o | output | 4 | Per-loop state: 00 running, 01 three-stating, 10 powered down |

## Verification
Suppose a loop's sequencer state is wrong, for example it stays in the three-stating phase or skips it. The status field and sect_pd_o would then differ from the reference model on the first clock after the commit, or on the clock when the wait should end. A wrong latched bit shows up on cp_tristate_o, div_hold_o or ref_en_o in the cycle after the commit. The bench compares every output on every clock, so each such fault is seen within one cycle of when it first affects the ports.

// File: rtl/dual_pd_pkg.sv
package dual_pd_pkg;
  typedef enum logic [1:0] {
    ST_RUN = 2'd0,
    ST_TRI = 2'd1,
    ST_OFF = 2'd2
  } loop_st_e;
endpackage

// File: rtl/dual_pd_latch.sv
module dual_pd_latch #(
  parameter int N_LOOPS = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               commit_i,
  input  logic [N_LOOPS-1:0] pd_i,
  input  logic [N_LOOPS-1:0] tri_i,
  input  logic [N_LOOPS-1:0] crst_i,
  output logic [N_LOOPS-1:0] pd_q_o,
  output logic [N_LOOPS-1:0] tri_q_o,
  output logic [N_LOOPS-1:0] crst_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pd_q_o   <= '0;
      tri_q_o  <= '0;
      crst_q_o <= '0;
    end else if (commit_i) begin
      pd_q_o   <= pd_i;
      tri_q_o  <= tri_i;
      crst_q_o <= crst_i;
    end
  end

  assert_hold_no_commit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(pd_q_o) && $stable(tri_q_o) && $stable(crst_q_o));
endmodule

// File: rtl/dual_pd_loop_seq.sv
module dual_pd_loop_seq
  import dual_pd_pkg::*;
#(
  parameter int PD_WAIT = 2,
  localparam int CNT_W  = (PD_WAIT > 1) ? $clog2(PD_WAIT) : 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       commit_i,
  input  logic       pd_i,
  input  logic       tri_i,
  input  logic       tri_q_i,
  input  logic       crst_q_i,
  output logic       cp_tristate_o,
  output logic       div_hold_o,
  output logic       sect_pd_o,
  output logic [1:0] status_o
);
  loop_st_e         st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wait_done;

  assign wait_done = (cnt_q == CNT_W'(PD_WAIT - 1));

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (commit_i) begin
      if (!pd_i) begin
        st_d = ST_RUN;
      end else if (tri_i) begin
        st_d = ST_OFF;      // pump already three-stated: go down at once
      end else if (st_q == ST_RUN) begin
        st_d  = ST_TRI;     // graceful path: three-state first
        cnt_d = '0;
      end
    end else if (st_q == ST_TRI) begin
      if (wait_done) st_d = ST_OFF;
      else           cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_RUN;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign cp_tristate_o = tri_q_i | crst_q_i | (st_q != ST_RUN);
  assign div_hold_o    = crst_q_i | (st_q == ST_OFF);
  assign sect_pd_o     = (st_q == ST_OFF);
  assign status_o      = st_q;

  assert_sync_enter_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && commit_i && pd_i && !tri_i) |=> (status_o == 2'b01) && !sect_pd_o);
  assert_wait_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_TRI) |-> (int'(cnt_q) < PD_WAIT));
  assert_async_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && pd_i && tri_i) |=> sect_pd_o && (status_o == 2'b10));
  assert_off_outputs_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sect_pd_o |-> cp_tristate_o && div_hold_o);
  assert_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !pd_i) |=> !sect_pd_o && (status_o == 2'b00));
  assert_crst_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crst_q_i |-> div_hold_o && cp_tristate_o);
  assert_status_legal_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o != 2'b11);
endmodule

// File: rtl/dual_pd_ref_gate.sv
module dual_pd_ref_gate #(
  parameter int N_LOOPS = 2
) (
  input  logic [N_LOOPS-1:0] pd_q_i,
  output logic               ref_en_o
);
  assign ref_en_o = ~(&pd_q_i);
endmodule

// File: rtl/dual_pd_ctrl.sv
module dual_pd_ctrl #(
  parameter int PD_WAIT = 2,
  localparam int N_LOOPS = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 commit_i,
  input  logic [N_LOOPS-1:0]   pd_i,
  input  logic [N_LOOPS-1:0]   tri_i,
  input  logic [N_LOOPS-1:0]   crst_i,
  output logic [N_LOOPS-1:0]   cp_tristate_o,
  output logic [N_LOOPS-1:0]   div_hold_o,
  output logic [N_LOOPS-1:0]   sect_pd_o,
  output logic                 ref_en_o,
  output logic [2*N_LOOPS-1:0] status_o
);
  logic [N_LOOPS-1:0] pd_q, tri_q, crst_q;

  dual_pd_latch #(.N_LOOPS(N_LOOPS)) u_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (commit_i),
    .pd_i     (pd_i),
    .tri_i    (tri_i),
    .crst_i   (crst_i),
    .pd_q_o   (pd_q),
    .tri_q_o  (tri_q),
    .crst_q_o (crst_q)
  );

  for (genvar l = 0; l < N_LOOPS; l++) begin : g_loop
    dual_pd_loop_seq #(.PD_WAIT(PD_WAIT)) u_seq (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .commit_i      (commit_i),
      .pd_i          (pd_i[l]),
      .tri_i         (tri_i[l]),
      .tri_q_i       (tri_q[l]),
      .crst_q_i      (crst_q[l]),
      .cp_tristate_o (cp_tristate_o[l]),
      .div_hold_o    (div_hold_o[l]),
      .sect_pd_o     (sect_pd_o[l]),
      .status_o      (status_o[2*l +: 2])
    );
  end

  dual_pd_ref_gate #(.N_LOOPS(N_LOOPS)) u_ref (
    .pd_q_i   (pd_q),
    .ref_en_o (ref_en_o)
  );

  assert_ref_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && (&pd_i)) |=> !ref_en_o);
  assert_ref_on_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !(&pd_i)) |=> ref_en_o);
  assert_tri_only_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && (tri_i == 2'b11) && (pd_i == 2'b00) && (crst_i == 2'b00))
    |=> (cp_tristate_o == 2'b11) && (div_hold_o == 2'b00) && (sect_pd_o == 2'b00));
endmodule

// File: tb/tb_dual_pd_ctrl.sv
`timescale 1ns/1ps
module tb_dual_pd_ctrl;
  localparam int PD_WAIT = 2;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       commit_i = 1'b0;
  logic [1:0] pd_i = '0, tri_i = '0, crst_i = '0;
  logic [1:0] cp_tristate_o, div_hold_o, sect_pd_o;
  logic       ref_en_o;
  logic [3:0] status_o;

  int checks = 0;
  int failures = 0;

  // reference model state
  int m_st[2];
  int m_cnt[2];
  bit m_pd[2], m_tri[2], m_crst[2];

  always #2 clk = ~clk;

  dual_pd_ctrl #(.PD_WAIT(PD_WAIT)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .commit_i(commit_i),
    .pd_i(pd_i), .tri_i(tri_i), .crst_i(crst_i),
    .cp_tristate_o(cp_tristate_o), .div_hold_o(div_hold_o),
    .sect_pd_o(sect_pd_o), .ref_en_o(ref_en_o), .status_o(status_o)
  );

  task automatic model_reset();
    for (int l = 0; l < 2; l++) begin
      m_st[l] = 0; m_cnt[l] = 0; m_pd[l] = 0; m_tri[l] = 0; m_crst[l] = 0;
    end
  endtask

  task automatic model_step();
    for (int l = 0; l < 2; l++) begin
      if (commit_i) begin
        m_pd[l] = pd_i[l]; m_tri[l] = tri_i[l]; m_crst[l] = crst_i[l];
        if (!pd_i[l]) m_st[l] = 0;
        else if (tri_i[l]) m_st[l] = 2;
        else if (m_st[l] == 0) begin m_st[l] = 1; m_cnt[l] = 0; end
      end else if (m_st[l] == 1) begin
        if (m_cnt[l] == PD_WAIT - 1) m_st[l] = 2;
        else m_cnt[l]++;
      end
    end
  endtask

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    for (int l = 0; l < 2; l++) begin
      chk(tag, $sformatf("loop%0d status", l), int'(status_o[2*l +: 2]), m_st[l]);
      chk(tag, $sformatf("loop%0d cp_tristate", l), int'(cp_tristate_o[l]),
          int'(m_tri[l] || m_crst[l] || m_st[l] != 0));
      chk(tag, $sformatf("loop%0d div_hold", l), int'(div_hold_o[l]),
          int'(m_crst[l] || m_st[l] == 2));
      chk(tag, $sformatf("loop%0d sect_pd", l), int'(sect_pd_o[l]), int'(m_st[l] == 2));
    end
    chk(tag, "ref_en", int'(ref_en_o), int'(!(m_pd[0] && m_pd[1])));
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(input string tag, input bit le, input logic [1:0] pd,
                     input logic [1:0] tr, input logic [1:0] cr);
    commit_i = le; pd_i = pd; tri_i = tr; crst_i = cr;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) cyc(tag, 1'b0, pd_i, tri_i, crst_i);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    compare("R1");
    chk("R1", "status after reset", int'(status_o), 0);
    chk("R1", "ref_en after reset", int'(ref_en_o), 1);
    rst_ni = 1'b1;
    @(negedge clk);
    compare("R1");

    // R2: inputs toggle without commit
    cyc("R2", 1'b0, 2'b11, 2'b01, 2'b11);
    cyc("R2", 1'b0, 2'b10, 2'b10, 2'b01);
    chk("R2", "sect_pd unchanged", int'(sect_pd_o), 0);
    chk("R2", "div_hold unchanged", int'(div_hold_o), 0);

    // R3 sync path on IF, R10 independence of RF
    cyc("R3", 1'b1, 2'b01, 2'b00, 2'b00);
    chk("R3", "IF three-stating", int'(status_o[1:0]), 1);
    chk("R10", "RF untouched", int'(status_o[3:2]), 0);
    cyc("R3", 1'b0, 2'b00, 2'b00, 2'b00);
    chk("R3", "IF still three-stating", int'(sect_pd_o[0]), 0);
    cyc("R3", 1'b0, 2'b00, 2'b00, 2'b00);
    chk("R5", "IF down after wait", int'(sect_pd_o[0]), 1);
    chk("R5", "IF hold", int'(div_hold_o[0]), 1);
    idle("R5", 3);

    // R6 both down via async on RF
    cyc("R4", 1'b1, 2'b11, 2'b10, 2'b00);
    chk("R4", "RF down at commit", int'(status_o[3:2]), 2);
    chk("R6", "ref off", int'(ref_en_o), 0);
    idle("R6", 2);

    // R7 release IF only
    cyc("R7", 1'b1, 2'b10, 2'b10, 2'b00);
    chk("R7", "IF running", int'(status_o[1:0]), 0);
    chk("R6", "ref on", int'(ref_en_o), 1);
    cyc("R7", 1'b1, 2'b00, 2'b00, 2'b00);
    chk("R7", "RF running", int'(sect_pd_o), 0);

    // R7 abort mid sync
    cyc("R7", 1'b1, 2'b10, 2'b00, 2'b00);
    cyc("R7", 1'b1, 2'b00, 2'b00, 2'b00);
    chk("R7", "abort mid wait", int'(status_o), 0);
    idle("R7", 3);

    // sync then async escalation during wait (R4)
    cyc("R3", 1'b1, 2'b11, 2'b00, 2'b00);
    cyc("R4", 1'b1, 2'b11, 2'b11, 2'b00);
    chk("R4", "both down early", int'(sect_pd_o), 3);
    idle("R4", 2);
    cyc("R7", 1'b1, 2'b00, 2'b00, 2'b00);

    // R8 counter reset separate and together
    cyc("R8", 1'b1, 2'b00, 2'b00, 2'b01);
    chk("R8", "IF hold", int'(div_hold_o), 1);
    idle("R8", 2);
    cyc("R8", 1'b1, 2'b00, 2'b00, 2'b11);
    chk("R8", "both hold", int'(cp_tristate_o), 3);
    cyc("R8", 1'b1, 2'b00, 2'b00, 2'b00);
    chk("R8", "released together", int'(div_hold_o), 0);

    // R9 three-state only
    cyc("R9", 1'b1, 2'b00, 2'b11, 2'b00);
    chk("R9", "pump off, loop running", int'(status_o), 0);
    chk("R9", "cp three-state", int'(cp_tristate_o), 3);
    idle("R9", 2);
    cyc("R9", 1'b1, 2'b00, 2'b00, 2'b00);

    // reset mid sequence
    cyc("R3", 1'b1, 2'b11, 2'b00, 2'b10);
    rst_ni = 1'b0;
    model_reset();
    #1;
    compare("R1");
    @(negedge clk);
    rst_ni = 1'b1;
    commit_i = 0;
    idle("R1", 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule